// File: doc/BRIEF.md
# Radix-4 Booth Partial Product Generator

This block forms the partial product bit matrix for a signed two's-complement multiplication using radix-4 Booth recoding. The multiplier operand X is cut into overlapping three-bit windows, each selecting a multiple of the multiplicand Y from the set {0, +1, +2, -1, -2}. Each selected multiple becomes one row of bits, positioned two columns above the previous row. Sign extension is not replicated across the full width. Instead, each row's top bit is inverted and a constant one is placed just above it. The first row instead receives a two-bit extension (its top bit repeated, then inverted). The increment that completes a negation is emitted as a separate bit per row.

A downstream compressor tree and final adder, which are outside this block, add every emitted bit column by column. Carries at or above column XW+YW are dropped. The truncated unsigned sum equals the signed product X*Y. The rows are registered once, so the matrix appears one clock after the operands. A synchronous active-low reset clears the matrix to all zeros.

Top module: `booth_pp_gen`

## Requirements
- R1: The operand X is extended with a zero below bit 0 and with its sign bit repeated above its top bit. Row k (k = 0 .. ceil(XW/2)-1) is recoded from extended bits {x[2k+1], x[2k], x[2k-1]}, where x[-1] = 0 and x[XW] = x[XW-1]. Row k occupies rows_o[k*XW+YW ... ] in slice rows_o[k*PW +: PW] (PW = XW+YW), already shifted left by 2k columns.
- R2: A window {b2,b1,b0} selects a multiple as follows: 000 and 111 select 0; 001 and 010 select +1; 011 selects +2; 100 selects -2; 101 and 110 select -1.
- R3: Row bit j (j = 0..YW) is formed from Y extended with a zero below bit 0 and its sign repeated at bit YW. The bit is y[j] for +1, y[j-1] for +2, the inverse of y[j] for -1, the inverse of y[j-1] for -2, and 0 for a zero multiple.
- R4: corr_o carries, in column 2k, the negation bit b2 & ~(b1 & b0) of row k. Every other column of corr_o is 0.
- R5: In every row k > 0, the bit in column 2k+YW is the inverse of row bit YW, and column 2k+YW+1 holds a constant 1.
- R6: In row 0, column YW+1 repeats row bit YW, and column YW+2 holds its inverse.
- R7: Any bit whose column would be XW+YW or higher is not emitted. For odd XW, this drops the constant 1 of the last row.
- R8: The sum of all row slices and corr_o, taken modulo 2^(XW+YW), equals the signed product X*Y. This includes the most negative values of either operand.
- R9: rows_o and corr_o reflect the operands sampled at the previous rising clock edge. While rst_n is low at a rising edge, both outputs are cleared to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| x_i | input | XW | Signed multiplier operand (recoded) |
| y_i | input | YW | Signed multiplicand operand |
| rows_o | output | NR*(XW+YW) | Placed partial product rows, row k in slice k |
| corr_o | output | XW+YW | Negation-increment bits, one per row at column 2k |

## Verification
Two mechanisms can act in the same column within a single cycle: the inverted-top-bit/constant-one sign handling and the per-row negation increment. They also collide with the column truncation when the last window draws its top bit from the duplicated sign of an odd-width X. These collisions are provoked in two ways: by directed most-negative and all-ones operands, and by sweeping every operand pair of an odd-width instance, where the last row's constant one falls off the top. Each case is judged by summing every emitted bit in the bench, truncating the sum, and comparing it with a signed product computed independently. Bit patterns of individual rows are also checked for the recoding corner windows.

// File: rtl/bpp_pkg.sv
// Package: shared types for the Booth partial product generator.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package bpp_pkg;

    // Decoded selection for one recoded window
    typedef struct packed {
        logic neg;   // multiple is negative (complement and add one)
        logic one;   // magnitude one: take y[j]
        logic two;   // magnitude two: take y[j-1]
    } booth_code_t;

    // Number of recoded rows for a multiplier of width xw
    function automatic int unsigned row_count(input int unsigned xw);
        return (xw + 1) / 2;
    endfunction

endpackage

// File: rtl/bpp_recoder.sv
// Module: bpp_recoder
// Decodes one three-bit window of the extended multiplier into a
// magnitude/sign selection. Purely combinational; the window is
// assumed already extended with the low zero and duplicated sign.
module bpp_recoder
    import bpp_pkg::*;
(
    input  logic [2:0]  win_i,
    output booth_code_t code_o
);

    // Map window to {neg, one, two}; 000 and 111 give no selection
    always_comb begin
        code_o.one = win_i[1] ^ win_i[0];
        code_o.two = (win_i[2] & ~win_i[1] & ~win_i[0]) |
                     (~win_i[2] & win_i[1] & win_i[0]);
        code_o.neg = win_i[2] & ~(win_i[1] & win_i[0]);
    end

endmodule

// File: rtl/bpp_row.sv
// Module: bpp_row
// Builds one unshifted partial product row of YW+3 bits from a
// decoded window and the multiplicand. Bits 0..YW are the selected
// multiple (complemented when negative). The top two bits carry the
// sign handling: for the first row, a repeat of bit YW and its
// inverse; for later rows, bit YW inverted and a constant one above.
// Assumes YW >= 4.
module bpp_row
    import bpp_pkg::*;
#(
    parameter int YW    = 16,
    parameter bit FIRST = 1'b0
) (
    input  booth_code_t     code_i,
    input  logic [YW-1:0]   y_i,
    output logic [YW+2:0]   bits_o
);

    localparam int EW = YW + 2;   // extended multiplicand width

    logic [EW-1:0] y_ext;         // {sign, y, 0}
    logic [YW:0]   sel;           // selected and sign-applied bits

    // Extend the multiplicand with a low zero and a repeated sign
    always_comb begin
        y_ext = {y_i[YW-1], y_i, 1'b0};
    end

    // Select y[j] or y[j-1] per bit and complement for negative multiples
    always_comb begin
        for (int j = 0; j <= YW; j++) begin
            logic raw;
            raw    = code_i.one ? y_ext[j+1] : (code_i.two ? y_ext[j] : 1'b0);
            sel[j] = raw ^ code_i.neg;
        end
    end

    generate
        if (FIRST) begin : g_first
            // First row: repeat the top bit, then place its inverse
            always_comb begin
                bits_o = {~sel[YW], sel[YW], sel};
            end
        end else begin : g_later
            // Later rows: invert the top bit and add a constant one above
            always_comb begin
                bits_o = {1'b1, ~sel[YW], sel[YW-1:0]};
            end
        end
    endgenerate

endmodule

// File: rtl/booth_pp_gen.sv
// Module: booth_pp_gen
// Radix-4 Booth partial product generator. It recodes X in windows
// stepping by two and builds one row per window, placed at column 2k
// and truncated to XW+YW bits. It also collects the negation bits into
// a separate correction vector. One register stage with a synchronous
// active-low reset sits on the outputs.
// Assumes XW >= 4 and YW >= XW; both operands are two's complement.
module booth_pp_gen
    import bpp_pkg::*;
#(
    parameter int XW = 16,
    parameter int YW = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [XW-1:0]              x_i,
    input  logic [YW-1:0]              y_i,
    output logic [row_count(XW)*(XW+YW)-1:0] rows_o,
    output logic [XW+YW-1:0]           corr_o
);

    localparam int NR   = row_count(XW);   // recoded rows
    localparam int PW   = XW + YW;         // product width
    localparam int RW   = YW + 3;          // unshifted row width
    localparam int WIDE = PW + RW;         // room for shifting
    localparam int XEW  = 2 * NR + 1;      // extended multiplier width

    logic [XEW-1:0]     x_ext;
    booth_code_t        code   [NR];
    logic [NR*PW-1:0]   rows_next;
    logic [PW-1:0]      corr_next;

    // Extend X with a low zero; odd widths also take a repeated sign bit
    always_comb begin
        x_ext = XEW'({x_i[XW-1], x_i, 1'b0});
    end

    generate
        for (genvar k = 0; k < NR; k++) begin : g_row
            logic [RW-1:0]   bits;
            logic [WIDE-1:0] shifted;

            bpp_recoder u_rec (
                .win_i  (x_ext[2*k+2:2*k]),
                .code_o (code[k])
            );

            bpp_row #(
                .YW    (YW),
                .FIRST (k == 0)
            ) u_row (
                .code_i (code[k]),
                .y_i    (y_i),
                .bits_o (bits)
            );

            // Place the row at column 2k and drop columns at or above PW
            always_comb begin
                shifted                = WIDE'(bits) << (2 * k);
                rows_next[k*PW +: PW]  = shifted[PW-1:0];
            end
        end
    endgenerate

    // Gather each row's negation bit into its lowest column
    always_comb begin
        corr_next = '0;
        for (int k = 0; k < NR; k++) begin
            corr_next[2*k] = code[k].neg;
        end
    end

    // Output register stage with synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows_o <= '0;
            corr_o <= '0;
        end else begin
            rows_o <= rows_next;
            corr_o <= corr_next;
        end
    end

endmodule

// File: rtl/booth_pp_gen_chk.sv
// Module: booth_pp_gen_chk
// Property checker for booth_pp_gen, attached by bind. It observes
// only the ports of the generator.
module booth_pp_gen_chk
    import bpp_pkg::*;
#(
    parameter int XW = 16,
    parameter int YW = 16
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [XW-1:0]                   x_i,
    input logic [YW-1:0]                   y_i,
    input logic [row_count(XW)*(XW+YW)-1:0] rows_o,
    input logic [XW+YW-1:0]                corr_o
);

    localparam int NR = row_count(XW);
    localparam int PW = XW + YW;

    // Columns where a negation bit may appear
    function automatic logic [PW-1:0] even_mask();
        logic [PW-1:0] m;
        m = '0;
        for (int k = 0; k < NR; k++) m[2*k] = 1'b1;
        return m;
    endfunction

    // Expected placed row k when X is zero (multiple 0 in every window)
    function automatic logic [PW-1:0] zero_row(input int k);
        logic [PW-1:0] r;
        r = '0;
        if (k == 0) begin
            r[YW+2] = 1'b1;
        end else begin
            r[2*k+YW] = 1'b1;
            if (2*k + YW + 1 < PW) r[2*k+YW+1] = 1'b1;
        end
        return r;
    endfunction

    localparam logic [PW-1:0] EVEN_MASK = even_mask();

    logic armed;
    logic was_rst;

    // Track whether the previous edge was taken in reset
    always_ff @(posedge clk) begin
        armed   <= 1'b1;
        was_rst <= !rst_n;
    end

    // R9
    always @(posedge clk) begin
        if (armed && was_rst) begin
            reset_clear_chk: assert (rows_o == '0 && corr_o == '0)
                else $error("outputs not cleared after reset edge");
        end
    end

    // R4
    corr_even_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_o & ~EVEN_MASK) == '0);

    // R4
    zero_x_no_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_i == '0) |=> (corr_o == '0));

    // R6
    zero_x_row0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_i == '0) |=> (rows_o[PW-1:0] == zero_row(0)));

    // R5 and R7
    generate
        for (genvar k = 1; k < NR; k++) begin : g_zr
            zero_x_rowk_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (x_i == '0) |=> (rows_o[k*PW +: PW] == zero_row(k)));
        end
    endgenerate

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && $stable(x_i) && $stable(y_i))
        |=> ($stable(rows_o) && $stable(corr_o)));

endmodule

bind booth_pp_gen booth_pp_gen_chk #(.XW(XW), .YW(YW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .x_i    (x_i),
    .y_i    (y_i),
    .rows_o (rows_o),
    .corr_o (corr_o)
);

// File: tb/booth_pp_gen_tb_top.sv
// Bench for booth_pp_gen: a wide even-width instance driven by random and
// directed operands, and an odd-width instance swept exhaustively.
module booth_pp_gen_tb_top;

    localparam int AXW = 16, AYW = 16, APW = 32, ANR = 8;
    localparam int BXW = 5,  BYW = 7,  BPW = 12, BNR = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AXW-1:0] xa = '0;
    logic [AYW-1:0] ya = '0;
    logic [BXW-1:0] xb = '0;
    logic [BYW-1:0] yb = '0;
    logic [ANR*APW-1:0] rows_a;
    logic [APW-1:0]     corr_a;
    logic [BNR*BPW-1:0] rows_b;
    logic [BPW-1:0]     corr_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    booth_pp_gen #(.XW(AXW), .YW(AYW)) dut_i (
        .clk(clk), .rst_n(rst_n), .x_i(xa), .y_i(ya),
        .rows_o(rows_a), .corr_o(corr_a));

    booth_pp_gen #(.XW(BXW), .YW(BYW)) dut_odd_i (
        .clk(clk), .rst_n(rst_n), .x_i(xb), .y_i(yb),
        .rows_o(rows_b), .corr_o(corr_b));

    function automatic logic [APW-1:0] sum_a(input logic [ANR*APW-1:0] r,
                                             input logic [APW-1:0] c);
        logic [APW-1:0] s;
        s = c;
        for (int k = 0; k < ANR; k++) s = s + r[k*APW +: APW];
        return s;
    endfunction

    function automatic logic [BPW-1:0] sum_b(input logic [BNR*BPW-1:0] r,
                                             input logic [BPW-1:0] c);
        logic [BPW-1:0] s;
        s = c;
        for (int k = 0; k < BNR; k++) s = s + r[k*BPW +: BPW];
        return s;
    endfunction

    function automatic logic [APW-1:0] prod_a(input logic [AXW-1:0] x,
                                              input logic [AYW-1:0] y);
        longint p;
        p = longint'($signed(x)) * longint'($signed(y));
        return p[APW-1:0];
    endfunction

    function automatic logic [BPW-1:0] prod_b(input logic [BXW-1:0] x,
                                              input logic [BYW-1:0] y);
        longint p;
        p = longint'($signed(x)) * longint'($signed(y));
        return p[BPW-1:0];
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive both instances at a falling edge; results appear by the next one
    task automatic apply(input logic [AXW-1:0] x, input logic [AYW-1:0] y,
                         input logic [BXW-1:0] x2, input logic [BYW-1:0] y2);
        xa = x; ya = y; xb = x2; yb = y2;
        @(negedge clk);
    endtask

    task automatic check_sums(input string tag);
        check({tag, " R8 wide product"}, 64'(sum_a(rows_a, corr_a)), 64'(prod_a(xa, ya)));
        check({tag, " R8 odd product"},  64'(sum_b(rows_b, corr_b)), 64'(prod_b(xb, yb)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R8: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        // R9: outputs cleared while reset is held, even with nonzero operands
        xa = 16'h1234; ya = 16'h8765; xb = 5'h13; yb = 7'h55;
        repeat (3) @(negedge clk);
        check("R9 rows cleared in reset", 64'(|rows_a), 64'd0);
        check("R9 corr cleared in reset", 64'(corr_a), 64'd0);
        rst_n = 1'b1;

        // R6 R5 R4: zero multiplier gives only sign-handling bits
        apply(16'h0000, 16'h1234, 5'h00, 7'h2A);
        check("R6 row0 for zero X", 64'(rows_a[0 +: APW]), 64'h0004_0000);
        check("R5 row1 for zero X", 64'(rows_a[APW +: APW]), 64'h000C_0000);
        check("R4 no negation for zero X", 64'(corr_a), 64'd0);
        check("R7 odd last row drops constant one", 64'(rows_b[2*BPW +: BPW]), 64'h800);
        check_sums("zero");

        // R2 R3: +1 window copies Y with sign repeat in row 0
        apply(16'h0001, 16'h8001, 5'h01, 7'h40);
        check("R3 row0 for +1", 64'(rows_a[0 +: APW]), 64'h0003_8001);
        check_sums("plus1");

        // R2 R3 R4: -2 window shifts and complements, negation bit set
        apply(16'h0002, 16'h0001, 5'h02, 7'h01);
        check("R3 row0 for -2", 64'(rows_a[0 +: APW]), 64'h0003_FFFD);
        check("R4 negation bit for -2", 64'(corr_a), 64'd1);
        check_sums("minus2");

        // R1 R2: x=3 gives -1 in window 0 and +1 in window 1 (overlap)
        apply(16'h0003, 16'h0001, 5'h03, 7'h7F);
        check("R3 row0 for -1", 64'(rows_a[0 +: APW]), 64'h0003_FFFE);
        check("R1 row1 overlapping window", 64'(rows_a[APW +: APW]), 64'h000C_0004);
        check_sums("three");

        // R2 R4: all-ones X: window 111 selects zero above row 0
        apply(16'hFFFF, 16'h5A5A, 5'h1F, 7'h33);
        check("R4 only row0 negates for all ones", 64'(corr_a), 64'd1);
        check("R2 window 111 gives zero row", 64'(rows_a[APW +: APW]), 64'h000C_0000);
        check_sums("ones");

        // R1: odd X most negative uses the duplicated sign in the last window
        apply(16'h8000, 16'h8000, 5'h10, 7'h40);
        check("R1 odd sign duplication negation", 64'(corr_b), 64'h010);
        check_sums("mostneg");
        apply(16'h8000, 16'h7FFF, 5'h10, 7'h3F);
        check_sums("mostneg-max");
        apply(16'h7FFF, 16'h8000, 5'h0F, 7'h40);
        check_sums("max-mostneg");

        // R8: exhaustive odd instance, random wide instance alongside
        for (int i = 0; i < 32; i++) begin
            for (int j = 0; j < 128; j++) begin
                logic [AXW-1:0] rx;
                logic [AYW-1:0] ry;
                rx = AXW'($urandom);
                ry = AYW'($urandom);
                if (j == 0) rx = 16'h8000;
                if (j == 1) ry = 16'h8000;
                apply(rx, ry, BXW'(i), BYW'(j));
                check_sums("sweep");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule